// File: doc/BRIEF.md
# DMA Controller Register Bank

This block is the control and status register file of a multi-channel DMA engine. Software reaches it through a simple request/response port. The 4 KiB address space holds a small global region and, above it, a run of equal-sized windows, one per channel. Each channel window is 0x60 bytes long. That stride is not a power of two, so the block works out the channel number and the offset inside the window by dividing by the stride.

Writes pass through per-register masks. Identification and capability words answer reads but ignore writes. Illegal configurations, unmapped offsets and byte-wide accesses raise a one-cycle error pulse. Toward the transfer engine the block drives several things:
- enable and disable strobes for each channel;
- the current enable state of each channel;
- the 7-bit synchronisation selector of each channel;
- a sticky flag per channel. The flag is set whenever a transfer parameter of that channel is rewritten, and it holds until the engine acknowledges it.

A write that sets the soft-reset bit in the system configuration word returns the whole bank to its reset values.

Sequencing is done by a three-state machine. ST_IDLE holds `req_ready` high. On `req_valid` it captures the request and moves to ST_EXEC (transition IDLE→EXEC). ST_EXEC decodes the captured request and presents the response, the error pulse and the strobes. At the end of that cycle it commits any write and returns to ST_IDLE (EXEC→IDLE). If the write asked for a soft reset, it goes to ST_SRST instead (EXEC→SRST). ST_SRST spends one cycle returning every register to its reset value and then goes back to ST_IDLE (SRST→IDLE).

Top module: `dma_regbank`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every update flag and every enable state is 0. A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `rsp_valid` is then high for exactly the next cycle, and `req_ready` is low during that cycle.
- R2: The following global offsets are read-only and always read back fixed values, whatever is written to them:
  - 0x000 reads 0x00000040;
  - 0x028 reads 0x00000001;
  - 0x064, 0x06C, 0x070 and 0x074 read the parameters CAP0_VAL, CAP2_VAL, CAP3_VAL and CAP4_VAL.
  
  The channel current-position offsets 0x34, 0x38, 0x3C and 0x40 read 0. Writes to any of these offsets change nothing and raise no error.
- R3: `req_size` codes are 0 = byte, 1 = 16-bit and 2 = 32-bit. An access with size code 0 or 3 raises `err_pulse`, returns read data 0 and changes no state.
- R4: The following offsets are unmapped:
  - any global offset not listed in R2, R6 or R7;
  - channel-window offsets 0x0C and 0x48 to 0x5C;
  - any window whose channel number is NUM_CH or higher.
  
  An unmapped offset reads 0, ignores writes and raises `err_pulse`.
- R5: An address at or above 0x080 selects channel (address − 0x80) / 0x60. The register inside that channel's window is selected by the remainder.
- R6: The system configuration word at 0x02C stores the written value AND 0x3321. A write with bits 13:12 equal to 3 raises `err_pulse`, and the value is still stored. A write with bit 1 set leads to one ST_SRST cycle. During that cycle `soft_reset_pulse` is 1 and `req_ready` is 0. After it, every channel register, enable state and update flag is at reset, and the global configuration word is back to its reset value. The system configuration word keeps the masked value that was written.
- R7: The global configuration word at 0x078 resets to 0x00010010 and stores the written value AND 0x00FF00FF. A write whose low byte is zero raises `err_pulse`, and the value is still stored.
- R8: The channel control word (window offset 0x00) stores the written value AND 0x039FF1FF. Bit 7 is the channel enable:
  - a write that changes bit 7 from 0 to 1 pulses `ch_en_stb` for that channel in the response cycle;
  - a write that changes bit 7 from 1 to 0 pulses `ch_dis_stb` in the response cycle;
  - `ch_enabled` follows the stored bit 7.
  
  The channel's `ch_sync` output is {bits 20:19, bits 4:0} of the stored control word.
- R9: The channel interrupt-control word (offset 0x08) resets to 0 and stores the written value AND 0x09BE. The link word (offset 0x04) stores bit 15, the link enable, and bits 4:0, the next channel, so its mask is 0x801F.
- R10: Writing any of the following transfer parameters sets that channel's update flag:
  - element count (offset 0x14, 24 bits);
  - frame count (offset 0x18, 16 bits);
  - source address (offset 0x1C) and destination address (offset 0x20);
  - the four index words at offsets 0x24, 0x28, 0x2C and 0x30. Offsets 0x24 and 0x2C hold 16 bits and read back sign-extended.
  
  The flag stays set until a cycle with `upd_ack` high clears it. If a set and an acknowledge fall in the same cycle, the set wins. The fill word (offset 0x44, 32 bits) does not set the flag.
- R11: The transfer-format word (offset 0x10) stores the written value AND 0x003FFFFF. A write whose data-type field, bits 1:0, equals 3 raises `err_pulse`, and the value is still stored.
- R12: In a 16-bit access, address bit 1 selects the upper (1) or lower (0) half of the addressed word. A write replaces only that half: it takes `req_wdata[15:0]`, applies the register's mask and leaves the other half unchanged. A read returns that half in `rsp_rdata[15:0]` with the upper 16 bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Bank can accept a request (ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the bank |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle (ST_EXEC) |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| err_pulse | output | 1 | Illegal access or configuration, in the response cycle |
| soft_reset_pulse | output | 1 | High during the soft-reset cycle |
| ch_en_stb | output | NUM_CH | Per-channel enable strobe |
| ch_dis_stb | output | NUM_CH | Per-channel disable strobe |
| ch_enabled | output | NUM_CH | Stored enable bit of each channel |
| ch_sync | output | 7*NUM_CH | Sync selector of each channel, 7 bits per channel |
| ch_upd | output | NUM_CH | Sticky transfer-parameter update flags |
| upd_ack | input | NUM_CH | Engine acknowledge, clears the update flag |

## Verification
Some behaviour can be checked on every cycle, and the assertions cover it:
- the one-request, one-response handshake and its single-cycle response;
- error pulses and strobes appearing only inside a response cycle;
- enable and disable strobes never firing together, and the enable state following each strobe;
- an update flag holding until an acknowledge or a soft reset;
- the soft-reset cycle following a response and leaving all flags and enables clear.

Other behaviour depends on data values, and only the bench scenarios can show it:
- the mask applied by each register;
- read-only words holding their values after being written;
- the divide-by-0x60 channel decode reaching the right window;
- 16-bit lane merging;
- which illegal field values raise the error pulse.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

    localparam int AW     = 12;
    localparam int DW     = 32;
    localparam int SYNC_W = 7;
    localparam int OFF_W  = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_SRST = 2'd2
    } rb_state_e;

    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // global offsets (low 7 bits, region below WIN_BASE)
    localparam logic [OFF_W-1:0] G_IDENT   = 7'h00;
    localparam logic [OFF_W-1:0] G_SYSSTAT = 7'h28;
    localparam logic [OFF_W-1:0] G_SYSCFG  = 7'h2C;
    localparam logic [OFF_W-1:0] G_CAPA    = 7'h64;
    localparam logic [OFF_W-1:0] G_CAPB    = 7'h6C;
    localparam logic [OFF_W-1:0] G_CAPC    = 7'h70;
    localparam logic [OFF_W-1:0] G_CAPD    = 7'h74;
    localparam logic [OFF_W-1:0] G_GLBCFG  = 7'h78;

    localparam logic [AW-1:0] WIN_BASE   = 12'h080;
    localparam logic [AW-1:0] WIN_STRIDE = 12'd96;

    // channel window offsets
    localparam logic [OFF_W-1:0] C_CTRL   = 7'h00;
    localparam logic [OFF_W-1:0] C_LINK   = 7'h04;
    localparam logic [OFF_W-1:0] C_IRQCTL = 7'h08;
    localparam logic [OFF_W-1:0] C_XFMT   = 7'h10;
    localparam logic [OFF_W-1:0] C_ELEM   = 7'h14;
    localparam logic [OFF_W-1:0] C_FRAME  = 7'h18;
    localparam logic [OFF_W-1:0] C_SRC    = 7'h1C;
    localparam logic [OFF_W-1:0] C_DST    = 7'h20;
    localparam logic [OFF_W-1:0] C_SEIDX  = 7'h24;
    localparam logic [OFF_W-1:0] C_SFIDX  = 7'h28;
    localparam logic [OFF_W-1:0] C_DEIDX  = 7'h2C;
    localparam logic [OFF_W-1:0] C_DFIDX  = 7'h30;
    localparam logic [OFF_W-1:0] C_POS0   = 7'h34;
    localparam logic [OFF_W-1:0] C_POS1   = 7'h38;
    localparam logic [OFF_W-1:0] C_POS2   = 7'h3C;
    localparam logic [OFF_W-1:0] C_POS3   = 7'h40;
    localparam logic [OFF_W-1:0] C_FILL   = 7'h44;

    localparam logic [DW-1:0] IDENT_VAL    = 32'h0000_0040;
    localparam logic [DW-1:0] SYSSTAT_VAL  = 32'h0000_0001;
    localparam logic [DW-1:0] SYSCFG_MASK  = 32'h0000_3321;
    localparam logic [DW-1:0] GLBCFG_MASK  = 32'h00FF_00FF;
    localparam logic [DW-1:0] GLBCFG_RST   = 32'h0001_0010;
    localparam logic [DW-1:0] CTRL_MASK    = 32'h039F_F1FF;
    localparam logic [DW-1:0] LINK_MASK    = 32'h0000_801F;
    localparam logic [DW-1:0] IRQCTL_MASK  = 32'h0000_09BE;
    localparam logic [DW-1:0] XFMT_MASK    = 32'h003F_FFFF;

    localparam int CTRL_EN_BIT   = 7;
    localparam int SYSCFG_SR_BIT = 1;

    // replace the 16-bit lanes selected by lo/hi, keep the rest
    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] cur,
                                                 input logic [DW-1:0] wd,
                                                 input logic lo, input logic hi);
        lane_merge = {hi ? wd[31:16] : cur[31:16], lo ? wd[15:0] : cur[15:0]};
    endfunction

    function automatic logic [SYNC_W-1:0] sync_sel(input logic [DW-1:0] ctrl);
        sync_sel = {ctrl[20:19], ctrl[4:0]};
    endfunction

endpackage

// File: rtl/dma_rb_ctrl.sv
module dma_rb_ctrl
    import dma_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    input  logic          go_srst,
    output rb_state_e     state,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic          srst_cycle,
    output logic          cap_write,
    output logic [AW-1:0] cap_addr,
    output logic [1:0]    cap_size,
    output logic [DW-1:0] cap_wdata
);

    rb_state_e state_nx;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cap_write <= 1'b0;
            cap_addr  <= '0;
            cap_size  <= '0;
            cap_wdata <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                cap_write <= req_write;
                cap_addr  <= req_addr;
                cap_size  <= req_size;
                cap_wdata <= req_wdata;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_EXEC;
            ST_EXEC: state_nx = go_srst ? ST_SRST : ST_IDLE;
            ST_SRST: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        srst_cycle = 1'b0;
        unique case (state)
            ST_IDLE: req_ready  = 1'b1;
            ST_EXEC: rsp_valid  = 1'b1;
            ST_SRST: srst_cycle = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_rb_glob.sv
module dma_rb_glob
    import dma_regbank_pkg::*;
#(
    parameter logic [31:0] CAP0_VAL = 32'h000C_0000,
    parameter logic [31:0] CAP2_VAL = 32'h0000_01FF,
    parameter logic [31:0] CAP3_VAL = 32'h0000_00F3,
    parameter logic [31:0] CAP4_VAL = 32'h0000_1FFE
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wd,
    input  logic             lane_lo,
    input  logic             lane_hi,
    output logic [DW-1:0]    rdata,
    output logic             hit,
    output logic             err,
    output logic             srst_req
);

    logic [DW-1:0] syscfg_q;
    logic [DW-1:0] glbcfg_q;
    logic [DW-1:0] mv;

    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        case (off)
            G_IDENT:   rdata = IDENT_VAL;
            G_SYSSTAT: rdata = SYSSTAT_VAL;
            G_SYSCFG:  rdata = syscfg_q;
            G_CAPA:    rdata = CAP0_VAL;
            G_CAPB:    rdata = CAP2_VAL;
            G_CAPC:    rdata = CAP3_VAL;
            G_CAPD:    rdata = CAP4_VAL;
            G_GLBCFG:  rdata = glbcfg_q;
            default:   hit   = 1'b0;
        endcase
    end

    assign mv = lane_merge(rdata, wd, lane_lo, lane_hi);

    assign srst_req = wr && (off == G_SYSCFG) && mv[SYSCFG_SR_BIT];
    assign err = wr && (((off == G_SYSCFG) && (mv[13:12] == 2'b11)) ||
                        ((off == G_GLBCFG) && (mv[7:0] == 8'h00)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syscfg_q <= '0;
            glbcfg_q <= GLBCFG_RST;
        end else if (srst) begin
            glbcfg_q <= GLBCFG_RST;
        end else if (wr) begin
            case (off)
                G_SYSCFG: syscfg_q <= mv & SYSCFG_MASK;
                G_GLBCFG: glbcfg_q <= mv & GLBCFG_MASK;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
    import dma_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              wr,
    input  logic [OFF_W-1:0]  off,
    input  logic [DW-1:0]     wd,
    input  logic              lane_lo,
    input  logic              lane_hi,
    input  logic              upd_ack,
    output logic [DW-1:0]     rdata,
    output logic              hit,
    output logic              err,
    output logic              en_stb,
    output logic              dis_stb,
    output logic              enabled,
    output logic [SYNC_W-1:0] sync,
    output logic              upd
);

    logic [DW-1:0] ctrl_q, link_q, irq_q, fmt_q, src_q, dst_q;
    logic [DW-1:0] sfi_q, dfi_q, fill_q;
    logic [23:0]   elem_q;
    logic [15:0]   frm_q, sei_q, dei_q;
    logic [DW-1:0] mv;
    logic          par_wr;

    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        case (off)
            C_CTRL:   rdata = ctrl_q;
            C_LINK:   rdata = link_q;
            C_IRQCTL: rdata = irq_q;
            C_XFMT:   rdata = fmt_q;
            C_ELEM:   rdata = {8'h00, elem_q};
            C_FRAME:  rdata = {16'h0000, frm_q};
            C_SRC:    rdata = src_q;
            C_DST:    rdata = dst_q;
            C_SEIDX:  rdata = {{16{sei_q[15]}}, sei_q};
            C_SFIDX:  rdata = sfi_q;
            C_DEIDX:  rdata = {{16{dei_q[15]}}, dei_q};
            C_DFIDX:  rdata = dfi_q;
            C_POS0, C_POS1, C_POS2, C_POS3: rdata = '0;
            C_FILL:   rdata = fill_q;
            default:  hit   = 1'b0;
        endcase
    end

    assign mv = lane_merge(rdata, wd, lane_lo, lane_hi);

    assign en_stb  = wr && (off == C_CTRL) &&  mv[CTRL_EN_BIT] && !ctrl_q[CTRL_EN_BIT];
    assign dis_stb = wr && (off == C_CTRL) && !mv[CTRL_EN_BIT] &&  ctrl_q[CTRL_EN_BIT];
    assign err     = wr && (off == C_XFMT) && (mv[1:0] == 2'b11);
    assign enabled = ctrl_q[CTRL_EN_BIT];
    assign sync    = sync_sel(ctrl_q);

    always_comb begin
        par_wr = 1'b0;
        if (wr) begin
            case (off)
                C_ELEM, C_FRAME, C_SRC, C_DST,
                C_SEIDX, C_SFIDX, C_DEIDX, C_DFIDX: par_wr = 1'b1;
                default: par_wr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; link_q <= '0; irq_q <= '0; fmt_q <= '0;
            elem_q <= '0; frm_q <= '0; src_q <= '0; dst_q <= '0;
            sei_q  <= '0; sfi_q <= '0; dei_q <= '0; dfi_q <= '0;
            fill_q <= '0;
        end else if (srst) begin
            ctrl_q <= '0; link_q <= '0; irq_q <= '0; fmt_q <= '0;
            elem_q <= '0; frm_q <= '0; src_q <= '0; dst_q <= '0;
            sei_q  <= '0; sfi_q <= '0; dei_q <= '0; dfi_q <= '0;
            fill_q <= '0;
        end else if (wr) begin
            case (off)
                C_CTRL:   ctrl_q <= mv & CTRL_MASK;
                C_LINK:   link_q <= mv & LINK_MASK;
                C_IRQCTL: irq_q  <= mv & IRQCTL_MASK;
                C_XFMT:   fmt_q  <= mv & XFMT_MASK;
                C_ELEM:   elem_q <= mv[23:0];
                C_FRAME:  frm_q  <= mv[15:0];
                C_SRC:    src_q  <= mv;
                C_DST:    dst_q  <= mv;
                C_SEIDX:  sei_q  <= mv[15:0];
                C_SFIDX:  sfi_q  <= mv;
                C_DEIDX:  dei_q  <= mv[15:0];
                C_DFIDX:  dfi_q  <= mv;
                C_FILL:   fill_q <= mv;
                default: ;
            endcase
        end
    end

    // update flag: set has priority over acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        upd <= 1'b0;
        else if (srst)     upd <= 1'b0;
        else if (par_wr)   upd <= 1'b1;
        else if (upd_ack)  upd <= 1'b0;
    end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int          NUM_CH   = 4,
    parameter logic [31:0] CAP0_VAL = 32'h000C_0000,
    parameter logic [31:0] CAP2_VAL = 32'h0000_01FF,
    parameter logic [31:0] CAP3_VAL = 32'h0000_00F3,
    parameter logic [31:0] CAP4_VAL = 32'h0000_1FFE
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [11:0]              req_addr,
    input  logic [1:0]               req_size,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic                     err_pulse,
    output logic                     soft_reset_pulse,
    output logic [NUM_CH-1:0]        ch_en_stb,
    output logic [NUM_CH-1:0]        ch_dis_stb,
    output logic [NUM_CH-1:0]        ch_enabled,
    output logic [NUM_CH*7-1:0]      ch_sync,
    output logic [NUM_CH-1:0]        ch_upd,
    input  logic [NUM_CH-1:0]        upd_ack
);

    rb_state_e     state;
    logic          cap_write;
    logic [AW-1:0] cap_addr;
    logic [1:0]    cap_size;
    logic [DW-1:0] cap_wdata;
    logic          go_srst;

    dma_rb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .go_srst(go_srst),
        .state(state), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .srst_cycle(soft_reset_pulse), .cap_write(cap_write),
        .cap_addr(cap_addr), .cap_size(cap_size), .cap_wdata(cap_wdata)
    );

    // decode of the captured request
    logic             exec, size_ok, is_half, lane_lo, lane_hi, wr_any;
    logic             glob_sel;
    logic [AW-1:0]    rel, widx;
    logic [OFF_W-1:0] woff, goff;
    logic [DW-1:0]    wd_lanes;

    assign exec     = (state == ST_EXEC);
    assign is_half  = (cap_size == SZ_HALF);
    assign size_ok  = is_half || (cap_size == SZ_WORD);
    assign lane_lo  = !is_half || !cap_addr[1];
    assign lane_hi  = !is_half ||  cap_addr[1];
    assign wd_lanes = is_half ? {cap_wdata[15:0], cap_wdata[15:0]} : cap_wdata;
    assign wr_any   = exec && cap_write && size_ok;
    assign glob_sel = (cap_addr < WIN_BASE);
    assign rel      = cap_addr - WIN_BASE;
    assign widx     = rel / WIN_STRIDE;
    assign woff     = OFF_W'(rel - widx * WIN_STRIDE) & 7'h7C;
    assign goff     = cap_addr[OFF_W-1:0] & 7'h7C;

    // global region
    logic [DW-1:0] g_rd;
    logic          g_hit, g_err, g_srst_req;

    dma_rb_glob #(
        .CAP0_VAL(CAP0_VAL), .CAP2_VAL(CAP2_VAL),
        .CAP3_VAL(CAP3_VAL), .CAP4_VAL(CAP4_VAL)
    ) u_glob (
        .clk(clk), .rst_n(rst_n), .srst(soft_reset_pulse),
        .wr(wr_any && glob_sel), .off(goff), .wd(wd_lanes),
        .lane_lo(lane_lo), .lane_hi(lane_hi),
        .rdata(g_rd), .hit(g_hit), .err(g_err), .srst_req(g_srst_req)
    );

    assign go_srst = g_srst_req;

    // channel windows
    logic [DW-1:0] c_rd  [NUM_CH];
    logic [NUM_CH-1:0] c_hit, c_err, c_sel;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign c_sel[i] = !glob_sel && (widx == AW'(i));
        dma_rb_chan u_chan (
            .clk(clk), .rst_n(rst_n), .srst(soft_reset_pulse),
            .wr(wr_any && c_sel[i]), .off(woff), .wd(wd_lanes),
            .lane_lo(lane_lo), .lane_hi(lane_hi), .upd_ack(upd_ack[i]),
            .rdata(c_rd[i]), .hit(c_hit[i]), .err(c_err[i]),
            .en_stb(ch_en_stb[i]), .dis_stb(ch_dis_stb[i]),
            .enabled(ch_enabled[i]), .sync(ch_sync[i*SYNC_W +: SYNC_W]),
            .upd(ch_upd[i])
        );
    end

    // read mux, hit and error merge
    logic [DW-1:0] sel_rd;
    logic          sel_hit, sel_err;

    always_comb begin
        sel_rd  = glob_sel ? g_rd  : '0;
        sel_hit = glob_sel && g_hit;
        sel_err = glob_sel && g_err;
        for (int i = 0; i < NUM_CH; i++) begin
            if (c_sel[i]) begin
                sel_rd  = sel_rd | c_rd[i];
                sel_hit = sel_hit | c_hit[i];
                sel_err = sel_err | c_err[i];
            end
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (exec && size_ok && !cap_write && sel_hit)
            rsp_rdata = is_half ? {16'h0000, (cap_addr[1] ? sel_rd[31:16] : sel_rd[15:0])}
                                : sel_rd;
    end

    assign err_pulse = exec && (!size_ok || !sel_hit || (cap_write && sel_err));

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
    parameter int NUM_CH = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              err_pulse,
    input logic              soft_reset_pulse,
    input logic [NUM_CH-1:0] ch_en_stb,
    input logic [NUM_CH-1:0] ch_dis_stb,
    input logic [NUM_CH-1:0] ch_enabled,
    input logic [NUM_CH-1:0] ch_upd,
    input logic [NUM_CH-1:0] upd_ack
);

    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);                          // R1
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                         // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);                                         // R1
    AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> rsp_valid);                                          // R4
    AST_SRST_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_pulse |-> ($past(rsp_valid) && !req_ready));            // R6
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_pulse |=> (ch_upd == '0 && ch_enabled == '0));          // R6
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en_stb & ch_dis_stb) == '0);                                   // R8
    AST_STB_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_en_stb) || (|ch_dis_stb)) |-> rsp_valid);                    // R8

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_EN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            ch_en_stb[i] |=> ch_enabled[i]);                               // R8
        AST_DIS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            ch_dis_stb[i] |=> !ch_enabled[i]);                             // R8
        AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_upd[i] && !upd_ack[i] && !soft_reset_pulse) |=> ch_upd[i]); // R10
    end

endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .err_pulse(err_pulse),
    .soft_reset_pulse(soft_reset_pulse), .ch_en_stb(ch_en_stb),
    .ch_dis_stb(ch_dis_stb), .ch_enabled(ch_enabled), .ch_upd(ch_upd),
    .upd_ack(upd_ack)
);

// File: tb/tb_dma_regbank.sv
`timescale 1ns/1ps
module tb_dma_regbank;

    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [1:0]       req_size = 2'd2;
    logic [31:0]      req_wdata = '0;
    logic             req_ready, rsp_valid, err_pulse, soft_reset_pulse;
    logic [31:0]      rsp_rdata;
    logic [NCH-1:0]   ch_en_stb, ch_dis_stb, ch_enabled, ch_upd;
    logic [NCH*7-1:0] ch_sync;
    logic [NCH-1:0]   upd_ack = '0;

    int n_total = 0, n_fail = 0;
    bit done = 0;

    logic [31:0]    g_rd;
    logic           g_err, g_rsp, g_rdy;
    logic [NCH-1:0] g_en, g_dis;

    always #5 clk = ~clk;

    dma_regbank #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .err_pulse(err_pulse), .soft_reset_pulse(soft_reset_pulse),
        .ch_en_stb(ch_en_stb), .ch_dis_stb(ch_dis_stb), .ch_enabled(ch_enabled),
        .ch_sync(ch_sync), .ch_upd(ch_upd), .upd_ack(upd_ack)
    );

    function automatic logic [11:0] cha(input int ch, input int off);
        cha = 12'(12'h080 + ch * 12'h060 + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access; samples the response cycle, returns after it
    task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        g_rd = rsp_rdata; g_err = err_pulse; g_rsp = rsp_valid; g_rdy = req_ready;
        g_en = ch_en_stb; g_dis = ch_dis_stb;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        acc(1'b0, a, 2'd2, 32'h0);
        chk(req, g_rd, exp);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no rsp after reset", 32'(rsp_valid), 32'd0);
        chk("R1 upd clear", 32'(ch_upd), 32'd0);
        chk("R1 enabled clear", 32'(ch_enabled), 32'd0);
        acc(1'b0, 12'h078, 2'd2, 0);
        chk("R1 rsp_valid in response", 32'(g_rsp), 32'd1);
        chk("R1 ready low in response", 32'(g_rdy), 32'd0);
        chk("R1 rsp one cycle", 32'(rsp_valid), 32'd0);
        chk("R7 glob cfg reset", g_rd, 32'h0001_0010);
        rd_chk("R9 irq ctl reset", cha(2, 8'h08), 32'h0);
    endtask

    task automatic t_readonly();
        rd_chk("R2 ident", 12'h000, 32'h40);
        rd_chk("R2 sys status", 12'h028, 32'h1);
        rd_chk("R2 cap0", 12'h064, 32'h000C_0000);
        rd_chk("R2 cap4", 12'h074, 32'h0000_1FFE);
        acc(1'b1, 12'h000, 2'd2, 32'hFFFF_FFFF);
        chk("R2 ident write no err", 32'(g_err), 32'd0);
        rd_chk("R2 ident after write", 12'h000, 32'h40);
        acc(1'b1, 12'h06C, 2'd2, 32'h0);
        rd_chk("R2 cap2 after write", 12'h06C, 32'h0000_01FF);
        acc(1'b1, cha(0, 8'h34), 2'd2, 32'h1234_5678);
        chk("R2 position write no err", 32'(g_err), 32'd0);
        rd_chk("R2 position reads zero", cha(0, 8'h34), 32'h0);
    endtask

    task automatic t_bytes();
        acc(1'b1, 12'h078, 2'd0, 32'h0000_0055);
        chk("R3 byte write err", 32'(g_err), 32'd1);
        rd_chk("R3 byte write no change", 12'h078, 32'h0001_0010);
        acc(1'b0, 12'h000, 2'd0, 0);
        chk("R3 byte read data", g_rd, 32'h0);
        chk("R3 byte read err", 32'(g_err), 32'd1);
        acc(1'b1, cha(1, 8'h44), 2'd3, 32'hFFFF_FFFF);
        chk("R3 size3 err", 32'(g_err), 32'd1);
        rd_chk("R3 size3 no change", cha(1, 8'h44), 32'h0);
    endtask

    task automatic t_unmapped();
        acc(1'b0, 12'h004, 2'd2, 0);
        chk("R4 global hole data", g_rd, 32'h0);
        chk("R4 global hole err", 32'(g_err), 32'd1);
        acc(1'b1, cha(0, 8'h0C), 2'd2, 32'hFFFF_FFFF);
        chk("R4 window 0x0C err", 32'(g_err), 32'd1);
        acc(1'b1, cha(1, 8'h48), 2'd2, 32'hFFFF_FFFF);
        chk("R4 window 0x48 err", 32'(g_err), 32'd1);
        acc(1'b1, cha(NCH, 8'h44), 2'd2, 32'hFFFF_FFFF);
        chk("R4 absent channel err", 32'(g_err), 32'd1);
        rd_chk("R4 absent channel reads 0", cha(NCH, 8'h44), 32'h0);
        rd_chk("R4 no alias in ch0 fill", cha(0, 8'h44), 32'h0);
    endtask

    task automatic t_decode();
        acc(1'b1, cha(2, 8'h44), 2'd2, 32'hA5A5_5A5A);
        chk("R5 write ch2 no err", 32'(g_err), 32'd0);
        rd_chk("R5 ch2 fill", 12'h184, 32'hA5A5_5A5A);
        rd_chk("R5 ch1 fill untouched", cha(1, 8'h44), 32'h0);
        rd_chk("R5 ch3 fill untouched", cha(3, 8'h44), 32'h0);
    endtask

    task automatic t_glbcfg();
        acc(1'b1, 12'h078, 2'd2, 32'hFFFF_FFFF);
        chk("R7 mask write no err", 32'(g_err), 32'd0);
        rd_chk("R7 mask", 12'h078, 32'h00FF_00FF);
        acc(1'b1, 12'h078, 2'd2, 32'h1234_0000);
        chk("R7 zero depth err", 32'(g_err), 32'd1);
        rd_chk("R7 zero depth stored", 12'h078, 32'h0034_0000);
    endtask

    task automatic t_ctrl();
        acc(1'b1, cha(1, 8'h00), 2'd2, 32'hFFFF_FFFF);
        chk("R8 enable strobe", 32'(g_en), 32'h2);
        chk("R8 no disable strobe", 32'(g_dis), 32'h0);
        chk("R8 enabled state", 32'(ch_enabled), 32'h2);
        chk("R8 sync all ones", 32'(ch_sync[7 +: 7]), 32'h7F);
        rd_chk("R8 ctrl mask", cha(1, 8'h00), 32'h039F_F1FF);
        acc(1'b1, cha(1, 8'h00), 2'd2, 32'h0018_0005);
        chk("R8 disable strobe", 32'(g_dis), 32'h2);
        chk("R8 no enable strobe", 32'(g_en), 32'h0);
        chk("R8 disabled state", 32'(ch_enabled), 32'h0);
        chk("R8 sync layout", 32'(ch_sync[7 +: 7]), 32'h65);
        acc(1'b1, cha(1, 8'h00), 2'd2, 32'h0000_0000);
        chk("R8 no strobe when unchanged", 32'(g_dis | g_en), 32'h0);
    endtask

    task automatic t_irqlink();
        acc(1'b1, cha(0, 8'h08), 2'd2, 32'hFFFF_FFFF);
        rd_chk("R9 irq ctl mask", cha(0, 8'h08), 32'h0000_09BE);
        acc(1'b1, cha(0, 8'h04), 2'd2, 32'hFFFF_FFFF);
        rd_chk("R9 link mask", cha(0, 8'h04), 32'h0000_801F);
    endtask

    task automatic t_xfmt();
        acc(1'b1, cha(0, 8'h10), 2'd2, 32'hFFFF_FFFF);
        chk("R11 data type 3 err", 32'(g_err), 32'd1);
        rd_chk("R11 format mask", cha(0, 8'h10), 32'h003F_FFFF);
        acc(1'b1, cha(0, 8'h10), 2'd2, 32'h0000_0002);
        chk("R11 data type 2 ok", 32'(g_err), 32'd0);
    endtask

    task automatic t_update();
        chk("R10 flags clear", 32'(ch_upd), 32'h0);
        acc(1'b1, cha(3, 8'h14), 2'd2, 32'hFFFF_FFFF);
        chk("R10 elem sets flag", 32'(ch_upd), 32'h8);
        rd_chk("R10 elem 24 bits", cha(3, 8'h14), 32'h00FF_FFFF);
        upd_ack[3] = 1'b1; @(negedge clk); upd_ack[3] = 1'b0;
        chk("R10 ack clears", 32'(ch_upd), 32'h0);
        acc(1'b1, cha(3, 8'h44), 2'd2, 32'h1);
        chk("R10 fill no flag", 32'(ch_upd), 32'h0);
        acc(1'b1, cha(3, 8'h18), 2'd2, 32'h1234_5678);
        rd_chk("R10 frame 16 bits", cha(3, 8'h18), 32'h0000_5678);
        upd_ack[3] = 1'b1; @(negedge clk); upd_ack[3] = 1'b0;
        upd_ack[3] = 1'b1;
        acc(1'b1, cha(3, 8'h24), 2'd2, 32'h0000_8000);
        chk("R10 set wins over ack", 32'(ch_upd), 32'h8);
        upd_ack[3] = 1'b0;
        rd_chk("R10 index sign extend", cha(3, 8'h24), 32'hFFFF_8000);
        chk("R10 flag holds", 32'(ch_upd), 32'h8);
        upd_ack[3] = 1'b1; @(negedge clk); upd_ack[3] = 1'b0;
        acc(1'b1, cha(2, 8'h30), 2'd2, 32'h1);
        chk("R10 dst frame index sets ch2", 32'(ch_upd), 32'h4);
        upd_ack[2] = 1'b1; @(negedge clk); upd_ack[2] = 1'b0;
    endtask

    task automatic t_half();
        acc(1'b1, cha(2, 8'h44), 2'd2, 32'h1122_3344);
        acc(1'b1, cha(2, 8'h46), 2'd1, 32'h0000_BEEF);
        rd_chk("R12 upper lane write", cha(2, 8'h44), 32'hBEEF_3344);
        acc(1'b0, cha(2, 8'h44), 2'd1, 0);
        chk("R12 lower lane read", g_rd, 32'h0000_3344);
        acc(1'b0, cha(2, 8'h46), 2'd1, 0);
        chk("R12 upper lane read", g_rd, 32'h0000_BEEF);
        acc(1'b1, cha(2, 8'h44), 2'd1, 32'hFFFF_0001);
        rd_chk("R12 lower lane write", cha(2, 8'h44), 32'hBEEF_0001);
    endtask

    task automatic t_srst();
        acc(1'b1, cha(1, 8'h00), 2'd2, 32'h0000_0080);
        acc(1'b1, cha(0, 8'h14), 2'd2, 32'h10);
        acc(1'b1, 12'h078, 2'd2, 32'h0022_0033);
        chk("R6 setup enabled", 32'(ch_enabled), 32'h2);
        acc(1'b1, 12'h02C, 2'd2, 32'h0000_1323);
        chk("R6 legal mode no err", 32'(g_err), 32'd0);
        chk("R6 soft reset cycle", 32'(soft_reset_pulse), 32'd1);
        chk("R6 not ready in soft reset", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R6 pulse one cycle", 32'(soft_reset_pulse), 32'd0);
        chk("R6 enables cleared", 32'(ch_enabled), 32'h0);
        chk("R6 flags cleared", 32'(ch_upd), 32'h0);
        rd_chk("R6 sys cfg masked", 12'h02C, 32'h0000_1321);
        rd_chk("R6 glob cfg reset", 12'h078, 32'h0001_0010);
        rd_chk("R6 channel reg reset", cha(2, 8'h44), 32'h0);
        acc(1'b1, 12'h02C, 2'd2, 32'h0000_3000);
        chk("R6 illegal mode err", 32'(g_err), 32'd1);
        chk("R6 no reset without bit1", 32'(soft_reset_pulse), 32'd0);
        rd_chk("R6 illegal mode stored", 12'h02C, 32'h0000_3000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readonly();
        t_bytes();
        t_unmapped();
        t_decode();
        t_glbcfg();
        t_ctrl();
        t_irqlink();
        t_xfmt();
        t_update();
        t_half();
        t_srst();
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule